// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped master for the extended (Clause 45) MDIO management protocol. A host programs the 16-bit target register number into an address register and then writes a command register. The command register holds the port address, the device address, the operation code and, for writes, the 16-bit data. The write to the command register starts the transaction.

Each transaction takes two frames on the serial pins. The first is an address frame that loads the target register number into the selected device. The second is a write frame or a read frame. The block generates MDC from the system clock and drives MDIO through an output/enable pair. During the turnaround and data bits of a read frame it releases MDIO and samples it on each rising edge of MDC. While both frames run, the command register shows busy. When a read finishes it shows read-valid, and the captured data appears in its low 16 bits.

Top module: `c45_mgmt_master`

## Requirements
- R1: After reset the command register (offset 0x0) and the address register (offset 0x8) read as zero, MDC is low and the MDIO output enable is low.
- R2: A write to offset 0x8 keeps only bits [15:0] as the target register number; the upper 16 bits read back as zero.
- R3: The command register has the port address in [20:16], the device address in [25:21], the operation in [28:26], read-valid in bit 29, busy in bit 30 and data in [15:0]. A command write starts a transaction only if the operation is 3'b101 (write) or 3'b111 (read). A command write with any other operation changes nothing.
- R4: The address frame is PRE_LEN one-bits, followed MSB first by 00, opcode 00, the 5-bit port address, the 5-bit device address, turnaround 10 and the 16-bit target register number.
- R5: The data frame that follows has the same preamble and layout. It carries opcode 01 plus the write data for a write, and opcode 11 for a read.
- R6: MDC has a period of 2*DIV_HALF clock cycles during a transaction and stays low when idle. MDIO and its enable change only while MDC is low, never during its high phase.
- R7: In a read frame the block releases MDIO from the first turnaround bit to the end of the frame. It captures the 16 data bits on the rising edges of MDC, MSB first, into command bits [15:0].
- R8: Busy is set from the clock after the starting write until the end of the second frame. Read-valid is set only when a read ends, and it is cleared when any new transaction starts.
- R9: While busy, writes to either register are ignored. The running frames and the readback of both registers are unaffected.
- R10: Whenever the block is not busy, the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO pin value |

## Verification
On every cycle the assertions check the following. MDC and the output enable are quiet when idle. MDIO holds steady through every MDC high phase. Read-valid can rise only on the cycle busy falls and is always clear just after a start. The captured fields do not move under a write issued while busy. Only the bench's scenarios can show the serial content: they decode every bit of both frames over a sweep of port, device, register and data values, and they measure the MDC period. They also check that read data driven by the modelled device lands in the right bit order, and that an invalid opcode or a mid-transaction write leaves the registers as they were.

// File: rtl/c45_pkg.sv
// Package: shared constants for the Clause 45 management master.
// Assumes 32-bit register data and byte offsets on the register bus.
package c45_pkg;
    localparam logic [2:0] OP_WRITE = 3'b101;
    localparam logic [2:0] OP_READ  = 3'b111;
    localparam int BIT_BUSY  = 30;
    localparam int BIT_VALID = 29;
    localparam logic [1:0] FR_ST   = 2'b00;
    localparam logic [1:0] FR_TA   = 2'b10;
    localparam logic [1:0] FROP_ADDR = 2'b00;
    localparam logic [1:0] FROP_WR   = 2'b01;
    localparam logic [1:0] FROP_RD   = 2'b11;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_DATA} seq_state_t;
endpackage

// File: rtl/c45_mdc_gen.sv
// Module: MDC generator. While enabled it toggles mdc every DIV_HALF clocks
// and flags the cycle before each rising and falling edge. While disabled it
// holds mdc low and the phase counter at zero.
module c45_mdc_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = $clog2(DIV_HALF + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap      = en && (cnt == CNT_LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // Phase counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/c45_frame_seq.sv
// Module: frame sequencer. On start it sends an address frame and then a
// data frame. Bits advance on MDC falling edges and read bits are sampled on
// rising edges. Assumes the command fields stay constant while busy.
module c45_frame_seq
    import c45_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  port_id,
    input  logic [4:0]  dev_id,
    input  logic [15:0] reg_num,
    input  logic [15:0] wr_data,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(PRE_LEN + 16);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [31:0]      word;
    logic             cur_bit;
    logic             released;

    assign busy = (state != SEQ_IDLE);
    assign done = (state == SEQ_DATA) && fall_tick && (idx == IDX_LAST);

    // Body of the current frame, after the preamble.
    always_comb begin
        if (state == SEQ_DATA)
            word = {FR_ST, is_read ? FROP_RD : FROP_WR, port_id, dev_id, FR_TA,
                    is_read ? 16'h0000 : wr_data};
        else
            word = {FR_ST, FROP_ADDR, port_id, dev_id, FR_TA, reg_num};
    end

    // Serial bit for the current position: preamble ones, then the word MSB first.
    always_comb begin
        if (int'(idx) < PRE_LEN)
            cur_bit = 1'b1;
        else
            cur_bit = word[5'(31 - (int'(idx) - PRE_LEN))];
    end

    assign released = (state == SEQ_DATA) && is_read && (idx >= IDX_TA);
    assign mdio_oe  = busy && !released;
    assign mdio_out = mdio_oe ? cur_bit : 1'b0;

    // Frame and bit position sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else if (state == SEQ_IDLE) begin
            if (start) begin
                state <= SEQ_ADDR;
                idx   <= '0;
            end
        end else if (fall_tick) begin
            if (idx == IDX_LAST) begin
                idx   <= '0;
                state <= (state == SEQ_ADDR) ? SEQ_DATA : SEQ_IDLE;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Read data capture on MDC rising edges, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rise_tick && released && idx >= IDX_DAT)
            rd_data <= {rd_data[14:0], mdio_in};
    end
endmodule

// File: rtl/c45_mgmt_master.sv
// Module: top of the Clause 45 management master. Holds the address and
// command registers, decodes bus writes and wires the MDC generator to the
// frame sequencer. Assumes one-cycle write strobes and byte offsets.
module c45_mgmt_master
    import c45_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DIV_HALF = 2,
    parameter int PRE_LEN  = 32,
    parameter logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] REG_OFS = ADDR_W'(8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic [15:0] reg_q;
    logic [4:0]  prt_q;
    logic [4:0]  dev_q;
    logic [2:0]  op_q;
    logic [15:0] data_q;
    logic        valid_q;
    logic        busy;
    logic        done;
    logic [15:0] rd_data;
    logic        rise_tick;
    logic        fall_tick;
    logic        start;
    logic [2:0]  wr_op;

    assign wr_op = bus_wdata[28:26];
    assign start = bus_wr && (bus_addr == CMD_OFS) && !busy &&
                   (wr_op == OP_WRITE || wr_op == OP_READ);

    // Target register number, writable only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (bus_wr && (bus_addr == REG_OFS) && !busy)
            reg_q <= bus_wdata[15:0];
    end

    // Command fields, data and read-valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prt_q   <= '0;
            dev_q   <= '0;
            op_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (start) begin
            prt_q   <= bus_wdata[20:16];
            dev_q   <= bus_wdata[25:21];
            op_q    <= wr_op;
            data_q  <= bus_wdata[15:0];
            valid_q <= 1'b0;
        end else if (done && op_q == OP_READ) begin
            data_q  <= rd_data;
            valid_q <= 1'b1;
        end
    end

    // Register readback mux.
    always_comb begin
        if (bus_addr == CMD_OFS)
            bus_rdata = {1'b0, busy, valid_q, op_q, dev_q, prt_q, data_q};
        else if (bus_addr == REG_OFS)
            bus_rdata = {16'h0000, reg_q};
        else
            bus_rdata = '0;
    end

    c45_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    c45_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_read   (op_q == OP_READ),
        .port_id   (prt_q),
        .dev_id    (dev_q),
        .reg_num   (reg_q),
        .wr_data   (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/c45_mgmt_checker.sv
// Module: protocol checker bound to the management master. Watches the pins
// and the command state and assumes nothing beyond the requirements.
module c45_mgmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mdc,
    input logic       mdio_out,
    input logic       mdio_oe,
    input logic       busy,
    input logic       rd_valid,
    input logic       bus_wr,
    input logic [2:0] op_q,
    input logic [4:0] prt_q,
    input logic [4:0] dev_q
);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    p_valid_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $fell(busy));

    p_start_clears_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rd_valid);

    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> ($stable(op_q) && $stable(prt_q) && $stable(dev_q)));
endmodule

bind c45_mgmt_master c45_mgmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .rd_valid (valid_q),
    .bus_wr   (bus_wr),
    .op_q     (op_q),
    .prt_q    (prt_q),
    .dev_q    (dev_q)
);

// File: tb/sim_c45_mgmt_master.sv
// Bench: sweeps port, device, register and data values through write and read
// transactions. A device model decodes every serial bit and supplies read data.
module sim_c45_mgmt_master;
    localparam int DIV_HALF = 2;
    localparam int PRE      = 32;
    localparam int FR       = PRE + 32;
    localparam int LIMIT    = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Device model state.
    int   obs [0:2*FR-1];
    int   k = 0;
    int   last_rise = 0;
    bit   period_bad = 0;
    bit   steady_bad = 0;
    bit   cur_rd = 0;
    logic [15:0] phy_val = '0;
    logic prev_mdc = 1'b0;
    logic hi_out, hi_oe;

    c45_mgmt_master #(.DIV_HALF(DIV_HALF), .PRE_LEN(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #10 clk = !clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Device model and watchdog, all sampled away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc >= LIMIT) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
            if (mdc && !prev_mdc) begin
                if (k > 0 && (cyc - last_rise) != 2*DIV_HALF) period_bad = 1;
                last_rise = cyc;
                if (k < 2*FR) obs[k] = mdio_oe ? int'(mdio_out) : 2;
                hi_out = mdio_out;
                hi_oe  = mdio_oe;
                k++;
            end else if (mdc && prev_mdc) begin
                if (mdio_out !== hi_out || mdio_oe !== hi_oe) steady_bad = 1;
            end else if (!mdc && prev_mdc) begin
                if (cur_rd && k >= FR+PRE+16 && k < 2*FR)
                    mdio_in = phy_val[15-(k-FR-PRE-16)];
                else
                    mdio_in = 1'b1;
            end
            prev_mdc = mdc;
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int exp_bit(int pos_all, bit rd, logic [4:0] p, logic [4:0] d,
                                   logic [15:0] ra, logic [15:0] wd);
        int f = pos_all / FR;
        int pos = pos_all % FR;
        logic [31:0] w;
        if (pos < PRE) return 1;
        if (f == 0) w = {4'b0000, p, d, 2'b10, ra};
        else w = {2'b00, rd ? 2'b11 : 2'b01, p, d, 2'b10, wd};
        if (f == 1 && rd && pos >= PRE + 14) return 2;
        return int'(w[31-(pos-PRE)]);
    endfunction

    task automatic wait_idle();
        logic [31:0] r;
        r = 32'hFFFF_FFFF;
        while (r[30]) bus_read(4'h0, r);
    endtask

    task automatic run_tx(input bit rd, input logic [4:0] p, input logic [4:0] d,
                          input logic [15:0] ra, input logic [15:0] wd,
                          input logic [15:0] pv, input bit poke);
        logic [31:0] r;
        int bad_a, bad_d;
        bus_write(4'h8, {16'hBEEF, ra});
        k = 0; period_bad = 0; steady_bad = 0; cur_rd = rd; phy_val = pv;
        bus_write(4'h0, {3'b000, rd ? 3'b111 : 3'b101, d, p, wd});
        bus_read(4'h0, r);
        check("R8 busy after start", {31'b0, r[30]}, 32'd1);
        check("R8 valid cleared at start", {31'b0, r[29]}, 32'd0);
        if (poke) begin
            bus_write(4'h0, {3'b000, 3'b111, ~d, ~p, ~wd});
            bus_write(4'h8, {16'h0, ~ra});
            bus_read(4'h8, r);
            check("R9 address reg unchanged while busy", r, {16'h0, ra});
        end
        wait_idle();
        bad_a = 0; bad_d = 0;
        for (int i = 0; i < 2*FR; i++) begin
            if (i < k && obs[i] != exp_bit(i, rd, p, d, ra, wd)) begin
                if (i < FR) bad_a++; else bad_d++;
            end
        end
        check("R6 rising edge count for two frames", k, 2*FR);
        check("R4 address frame bits mismatched", bad_a, 0);
        check(rd ? "R7 read frame bits mismatched" : "R5 write frame bits mismatched", bad_d, 0);
        check("R6 MDC period", {31'b0, period_bad}, 32'd0);
        check("R6 MDIO steady while MDC high", {31'b0, steady_bad}, 32'd0);
        check("R10 enable low when idle", {31'b0, mdio_oe}, 32'd0);
        bus_read(4'h0, r);
        check("R3 command readback", r,
              {1'b0, 1'b0, rd, rd ? 3'b111 : 3'b101, d, p, rd ? pv : wd});
        if (poke) check("R9 fields kept after busy write", {27'b0, r[20:16]}, {27'b0, p});
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read(4'h0, r);
        check("R1 command reg after reset", r, 32'h0);
        bus_read(4'h8, r);
        check("R1 address reg after reset", r, 32'h0);
        check("R1 mdc low", {31'b0, mdc}, 32'd0);
        check("R1 enable low", {31'b0, mdio_oe}, 32'd0);

        bus_write(4'h8, 32'hFFFF_1234);
        bus_read(4'h8, r);
        check("R2 upper bits dropped", r, 32'h0000_1234);

        for (int op = 0; op < 8; op++) begin
            if (op != 5 && op != 7) begin
                bus_write(4'h0, {3'b000, 3'(op), 5'd7, 5'd9, 16'hAAAA});
                repeat (4) @(negedge clk);
                bus_read(4'h0, r);
                check("R3 invalid opcode ignored", r, 32'h0);
                check("R10 no enable after invalid opcode", {31'b0, mdio_oe}, 32'd0);
            end
        end

        for (int i = 0; i < 6; i++) begin
            run_tx(1'b0, 5'(i*7+1), 5'(i*11+3), 16'(i*16'h2713 + 16'h0101),
                   16'(i*16'h1357 ^ 16'hC3A5), 16'h0, 1'b0);
            run_tx(1'b1, 5'(i*5+2), 5'(i*3+30), 16'(i*16'h0F0F ^ 16'h8001),
                   16'h0, 16'(i*16'h1111 ^ 16'hA5C3), 1'b0);
        end
        run_tx(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0, 16'hFFFF, 1'b0);
        run_tx(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0000, 16'h0, 1'b0);
        run_tx(1'b1, 5'd0, 5'd1, 16'h0001, 16'h0, 16'h0000, 1'b0);
        run_tx(1'b0, 5'd12, 5'd4, 16'h5A5A, 16'h0F0F, 16'h0, 1'b1);
        run_tx(1'b1, 5'd17, 5'd2, 16'hC001, 16'h0, 16'h8421, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule